// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is the storage and read-out path of a clocked static RAM with registered inputs. Every rising clock edge captures the word address, the select strobe, the write controls and the write data. A separate burst address controller supplies the word address and says whether the cycle is a selected access or a deselect. Within a selected access, the write-control decode decides between a read and a write. The word is split into four 9-bit byte lanes. Lane n occupies bits 9n+8 down to 9n, and each lane can be written on its own.

The static input `pipe_mode` picks the read latency. When it is low, the array output goes straight to `rdata` in the cycle after the read edge (flow-through). When it is high, the data passes through one more output register and appears one cycle later (pipelined). There are no tri-states: `rdrive` marks the cycles in which the output drivers would be on, and `rdata` is forced to zero whenever `rdrive` is low.

Two inputs act without waiting for a clock edge. The active-low `oe_n` can only switch off drivers that are already presenting read data. The active-high `sleep` blocks every access and keeps the array contents. A small power state machine has three states:
- PW_RUN: accesses are accepted.
- PW_SLEEP: entered at any edge where `sleep` is high.
- PW_WAKE: recovery after `sleep` falls.

Its transitions are:
- PW_RUN to PW_SLEEP when `sleep` is high at an edge.
- PW_SLEEP to PW_WAKE at the first edge with `sleep` low.
- PW_WAKE to PW_SLEEP when `sleep` is high again at an edge.
- PW_WAKE to PW_RUN once the recovery count has run out.

Top module: `sram_burst_dp`

## Requirements
- R1: After reset `rdrive` is low and `rdata` is zero.
- R2: With `pipe_mode`=0, a read captured at edge E sets `rdrive` high and puts the addressed word on `rdata` in the cycle between E and E+1.
- R3: With `pipe_mode`=1, a read captured at edge E is presented between E+1 and E+2. The word is the array content as of edge E+1, before any write at E+1. Back-to-back reads stream one word per cycle.
- R4: When `gwr_n` is low, a selected cycle writes all four lanes from `wdata`, whatever `bwr_n` and `lane_wr_n` are.
- R5: When `gwr_n` is high and `bwr_n` is low, lane n is written if and only if `lane_wr_n[n]` is 0, in any combination. If no lane bit is 0, the cycle is a read.
- R6: When `gwr_n` and `bwr_n` are both high, a selected cycle is a read. Write cycles and deselect cycles (`sel`=0) leave `rdrive` low in their own output slot, whichever lanes are enabled.
- R7: In pipelined mode, after a read at E and a deselect at E+1, `rdrive` is high only between E+1 and E+2 and is low from E+2 on. The deselect does not hold the drivers for an extra stage.
- R8: `oe_n` high forces `rdrive` low at once, without waiting for an edge. `oe_n` low turns drivers on only in a slot that holds read data. A read issued with `oe_n` high still fetches its word, which appears if `oe_n` falls within its slot.
- R9: While `sleep` is high, `rdrive` is low and reads and writes at any edge where `sleep` is high have no effect. Array contents are retained.
- R10: After `sleep` falls, the first WAKE_CYC edges (default 4) ignore commands. The edge after them accepts commands, and reads then return the data written before sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads (static) |
| sel | input | 1 | 1 = selected access, 0 = deselect cycle |
| addr | input | ADDR_W | Word address from the burst controller |
| gwr_n | input | 1 | Active-low write of all lanes |
| bwr_n | input | 1 | Active-low enable of per-lane writes |
| lane_wr_n | input | LANES | Active-low per-lane write select, bit n = lane n |
| wdata | input | LANES*LANE_W | Write data, captured with the write command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high low-power request, contents retained |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdrive | output | 1 | Output drivers on / read data valid |

## Verification
Two functions can fall in the same clock edge in pipelined mode. One is a write landing in the array. The other is the output register loading the word fetched by the previous read. The bench provokes this by writing to the same address right after reading it, and expects the pre-write word on the output (R3).

Two more overlaps are exercised. In one, `sleep` rises while a pipelined read is being presented, and the bench expects the drivers to go dark. In the other, `oe_n` toggles between edges inside a read slot. Random traffic with occasional sleep pulses is compared against a bench model of the array, the read latency and the wake-up count.

// File: rtl/sram_dp_pkg.sv
package sram_dp_pkg;

    typedef enum logic [1:0] {
        PW_RUN   = 2'd0,
        PW_SLEEP = 2'd1,
        PW_WAKE  = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             is_wr,
    output logic [LANES-1:0] lane_we
);

    always_comb begin
        if (!gwr_n) begin
            lane_we = '1;
        end else if (!bwr_n) begin
            lane_we = ~lane_wr_n;
        end else begin
            lane_we = '0;
        end
        is_wr = |lane_we;
    end

endmodule

// File: rtl/sram_pwr_fsm.sv
module sram_pwr_fsm
    import sram_dp_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic cmd_ok
);

    localparam int CNT_W = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);

    pwr_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PW_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PW_RUN: begin
                if (sleep) st_d = PW_SLEEP;
            end
            PW_SLEEP: begin
                if (!sleep) begin
                    st_d  = PW_WAKE;
                    cnt_d = CNT_W'(WAKE_CYC - 1);
                end
            end
            PW_WAKE: begin
                if (sleep) begin
                    st_d = PW_SLEEP;
                end else if (cnt_q == '0) begin
                    st_d = PW_RUN;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = PW_RUN;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ok = !sleep && ((st_q == PW_RUN) || (st_q == PW_WAKE && cnt_q == '0));
    end

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sleep) && $past(rst_n) |-> st_q == PW_SLEEP); // R9
    AST_RUN_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PW_RUN) && ($past(st_q) != PW_RUN) && $past(rst_n) |-> $past(st_q) == PW_WAKE); // R10

endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sram_burst_dp.sv
module sram_burst_dp #(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int WAKE_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    gwr_n,
    input  logic                    bwr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdrive
);

    localparam int DATA_W = LANES * LANE_W;

    logic             cmd_ok;
    logic             is_wr;
    logic [LANES-1:0] lane_we;
    logic             rd_acc, wr_acc;

    logic              s1_rd, s2_rd;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] arr_q, s2_data;
    logic              slot_v;
    logic [DATA_W-1:0] slot_d;

    sram_pwr_fsm #(.WAKE_CYC(WAKE_CYC)) pwr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .cmd_ok (cmd_ok)
    );

    sram_wr_decode #(.LANES(LANES)) dec_i (
        .gwr_n     (gwr_n),
        .bwr_n     (bwr_n),
        .lane_wr_n (lane_wr_n),
        .is_wr     (is_wr),
        .lane_we   (lane_we)
    );

    assign wr_acc = cmd_ok && sel && is_wr;
    assign rd_acc = cmd_ok && sel && !is_wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) lane_i (
            .clk   (clk),
            .we    (wr_acc && lane_we[g]),
            .waddr (addr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .raddr (s1_addr),
            .rdata (arr_q[g*LANE_W +: LANE_W])
        );
    end

    // capture stage and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_rd   <= 1'b0;
            s2_rd   <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_rd <= rd_acc;
            s2_rd <= s1_rd;
            if (rd_acc) s1_addr <= addr;
        end
    end

    always_ff @(posedge clk) begin
        s2_data <= arr_q;
    end

    // output drive
    always_comb begin
        slot_v = pipe_mode ? s2_rd : s1_rd;
        slot_d = pipe_mode ? s2_data : arr_q;
        rdrive = slot_v && !oe_n && !sleep;
        rdata  = rdrive ? slot_d : '0;
    end

    AST_FLOW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_mode && rdrive |-> $past(rd_acc)); // R2
    AST_PIPE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_mode && rdrive |-> $past(rd_acc, 2)); // R3
    AST_GW_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !gwr_n |-> &lane_we); // R4
    AST_BW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        gwr_n && !bwr_n |-> lane_we == ~lane_wr_n); // R5
    AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_mode && $past(wr_acc) |-> !rdrive); // R6
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdrive); // R8
    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdrive); // R9

endmodule

// File: tb/sram_burst_dp_tb.sv
module sram_burst_dp_tb_top;

    localparam int  AW   = 6;
    localparam int  WAKE = 4;
    localparam time TCK  = 5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_mode = 1'b0, b_sel = 1'b0, b_gw = 1'b1, b_bw = 1'b1;
    logic [3:0]  b_ln = 4'hF;
    logic [AW-1:0] b_addr = '0;
    logic [35:0] b_wd = '0;
    logic        b_oe = 1'b0, b_slp = 1'b0;
    logic [35:0] rdata;
    logic        rdrive;

    int nchk = 0, nerr = 0;
    bit done = 0;

    logic [35:0] mm [1 << AW];
    logic        f_v = 1'b0, p_v = 1'b0;
    logic [AW-1:0] f_a = '0;
    logic [35:0] p_d = '0;
    int          ign = 0;

    always #(TCK / 2) clk = ~clk;

    sram_burst_dp #(.ADDR_W(AW), .LANES(4), .LANE_W(9), .WAKE_CYC(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(b_mode), .sel(b_sel), .addr(b_addr),
        .gwr_n(b_gw), .bwr_n(b_bw), .lane_wr_n(b_ln), .wdata(b_wd),
        .oe_n(b_oe), .sleep(b_slp), .rdata(rdata), .rdrive(rdrive)
    );

    function automatic logic [3:0] wmask(logic gw, logic bw, logic [3:0] ln);
        if (!gw) return 4'hF;
        if (!bw) return ~ln;
        return 4'h0;
    endfunction

    function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] m);
        logic [35:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic auto_check();
        logic ev;
        logic [35:0] ed;
        string tag;
        ev = (b_mode ? p_v : f_v) && !b_oe && !b_slp;
        ed = b_mode ? p_d : mm[f_a];
        if (ev) tag = b_mode ? "R3" : "R2";
        else if (b_slp) tag = "R9";
        else if (b_oe) tag = "R8";
        else tag = "R6";
        chk(tag, {35'd0, rdrive}, {35'd0, ev});
        chk(tag, rdata, ev ? ed : 36'd0);
    endtask

    // called at a negedge with inputs set; returns at the next negedge after checking
    task automatic tick();
        logic acc;
        logic [3:0] m;
        if (b_slp) begin acc = 1'b0; ign = WAKE; end
        else if (ign > 0) begin acc = 1'b0; ign--; end
        else acc = 1'b1;
        m = wmask(b_gw, b_bw, b_ln);
        p_v = f_v;
        p_d = mm[f_a];
        if (acc && b_sel && (m != 0)) mm[b_addr] = merge(mm[b_addr], b_wd, m);
        f_v = acc && b_sel && (m == 0);
        if (f_v) f_a = b_addr;
        @(posedge clk);
        @(negedge clk);
        auto_check();
    endtask

    task automatic set_rd(logic [AW-1:0] a);
        b_sel = 1; b_gw = 1; b_bw = 1; b_ln = 4'hF; b_addr = a;
    endtask
    task automatic set_gw(logic [AW-1:0] a, logic [35:0] d);
        b_sel = 1; b_gw = 0; b_bw = 1; b_ln = 4'hF; b_addr = a; b_wd = d;
    endtask
    task automatic set_desel();
        b_sel = 0; b_gw = 1; b_bw = 1; b_ln = 4'hF;
    endtask

    initial begin
        #(TCK * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [35:0] keep;
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {35'd0, rdrive}, 36'd0);
        chk("R1", rdata, 36'd0);

        // fill the array, flow-through mode
        for (int i = 0; i < (1 << AW); i++) begin
            set_gw(AW'(i), 36'h5A5A5A5A5 ^ (36'(i) * 36'h01234567));
            tick();
        end

        // R4: global write ignores lane selects
        set_gw(6'd5, 36'h123456789); b_bw = 0; b_ln = 4'hF; tick();
        chk("R6", {35'd0, rdrive}, 36'd0);
        set_rd(6'd5); tick();
        chk("R2", {35'd0, rdrive}, 36'd1);
        chk("R4", rdata, 36'h123456789);

        // R5: byte write lanes 0 and 2
        b_sel = 1; b_gw = 1; b_bw = 0; b_ln = 4'b1010; b_addr = 6'd5; b_wd = 36'hFFFFFFFFF; tick();
        set_rd(6'd5); tick();
        chk("R5", rdata, merge(36'h123456789, 36'hFFFFFFFFF, 4'b0101));
        // byte-write enable with no lane selected is a read
        b_sel = 1; b_gw = 1; b_bw = 0; b_ln = 4'hF; b_addr = 6'd5; tick();
        chk("R5", {35'd0, rdrive}, 36'd1);
        set_desel(); tick();
        chk("R6", {35'd0, rdrive}, 36'd0);

        // R8: asynchronous output enable, and a dummy read
        set_rd(6'd3); tick();
        b_oe = 1; #1;
        chk("R8", {35'd0, rdrive}, 36'd0);
        b_oe = 0; #1;
        chk("R8", {35'd0, rdrive}, 36'd1);
        set_rd(6'd4); b_oe = 1; tick();
        b_oe = 0; #1;
        chk("R8", rdata, mm[4]);
        set_desel(); tick();

        // R3/R7: pipelined latency and single-cycle deselect
        b_mode = 1; tick();
        set_rd(6'd10); tick();
        chk("R3", {35'd0, rdrive}, 36'd0);
        set_rd(6'd11); tick();
        chk("R3", rdata, mm[10]);
        set_desel(); tick();
        chk("R3", rdata, mm[11]);
        tick();
        chk("R7", {35'd0, rdrive}, 36'd0);
        set_rd(6'd12); tick();
        set_desel(); tick();
        chk("R7", {35'd0, rdrive}, 36'd1);
        tick();
        chk("R7", {35'd0, rdrive}, 36'd0);

        // read then write same address: old word presented
        keep = mm[7];
        set_rd(6'd7); tick();
        set_gw(6'd7, 36'h0DEADBEEF); tick();
        chk("R3", rdata, keep);
        set_rd(6'd7); tick();
        set_desel(); tick();
        chk("R3", rdata, 36'h0DEADBEEF);
        // sleep arrives during a pipelined slot
        set_rd(6'd8); tick();
        set_desel(); b_slp = 1; tick();
        chk("R9", {35'd0, rdrive}, 36'd0);
        b_slp = 0; repeat (WAKE + 1) tick();

        // R9/R10: retention and wake-up recovery, flow mode
        b_mode = 0;
        set_gw(6'd9, 36'h0CAFEF00D); tick();
        b_slp = 1;
        for (int i = 0; i < 3; i++) begin
            set_gw(6'd9, 36'h111111111); tick();
            chk("R9", {35'd0, rdrive}, 36'd0);
        end
        set_rd(6'd9); tick();
        chk("R9", {35'd0, rdrive}, 36'd0);
        b_slp = 0;
        for (int i = 0; i < WAKE; i++) begin
            set_gw(6'd9, 36'h222222222); tick();
        end
        set_rd(6'd9); tick();
        chk("R10", {35'd0, rdrive}, 36'd1);
        chk("R10", rdata, 36'h0CAFEF00D);
        set_gw(6'd9, 36'h333333333); tick();
        set_rd(6'd9); tick();
        chk("R10", rdata, 36'h333333333);

        // random traffic in both modes
        for (int ph = 0; ph < 2; ph++) begin
            set_desel(); b_mode = ph[0]; tick(); tick();
            for (int n = 0; n < 400; n++) begin
                int r;
                r = int'($urandom_range(0, 99));
                b_sel  = (r < 85);
                b_addr = AW'($urandom);
                b_wd   = {4'($urandom), 32'($urandom)};
                b_ln   = 4'($urandom);
                r = int'($urandom_range(0, 99));
                b_gw   = !(r < 15);
                b_bw   = !(r >= 15 && r < 40);
                b_oe   = ($urandom_range(0, 99) < 10);
                b_slp  = ($urandom_range(0, 99) < 3);
                tick();
            end
            b_oe = 0; b_slp = 0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule